// File: doc/BRIEF.md
# Edge-Triggered Interrupt Cause Unit

This block sits beside a serial-peripheral transfer engine and turns the engine's level status flags into latched interrupt causes. Each flag is compared with its value from the previous clock. A change from 0 to 1 sets the matching cause bit, and that bit stays set until software clears it by writing a 1 to it. A flag that stays high does not set its cause again. A mask register selects which causes reach the single interrupt line. The line is a register that holds the OR of the masked causes.

Software reads the cause bits, the mask, and a registered copy of the level flags. Because of that copy, a driver can look at a condition that was already true before it armed the mask. Such a condition makes no new edge, so it would never raise an interrupt. Flag widths, and the bit a flag uses, are shared with the engine's status word, so one index names the same condition in all three views.

Top module: `edge_irq_status`

## Requirements
- R1: While the synchronous active-high reset is asserted, every cause bit, every mask bit, the level copy and the interrupt output are 0 after the next clock edge.
- R2: A flag that is 1 on a clock edge, when it was 0 on the edge before, sets its cause bit on that edge.
- R3: A flag that stays at 1 does not set its cause again after the cause has been cleared.
- R4: A clear write sets to 0 every cause bit where the written data has a 1 and keeps the other cause bits. Writing all ones clears every cause.
- R5: If a rising edge and a clear of the same bit arrive on the same clock edge, the cause bit stays set.
- R6: The interrupt output is registered. On each edge it takes the OR, over all bits, of cause AND mask as they stood before that edge.
- R7: When the mask is all zeros, the interrupt output is 0 one edge later, whatever causes are latched.
- R8: Clearing a mask bit keeps its latched cause. Setting the mask bit again while the cause is still latched raises the interrupt again.
- R9: Bit positions are shared with the engine's status word. Each position below holds one condition:

  | Bit | Condition |
  |---|---|
  | 0 | transfer done |
  | 1 | engine idle and ready |
  | 2 | receive queue ready |
  | 3 | transmit queue ready |
  | 4 | receive queue empty |
  | 5 | receive queue full |
  | 6 | transmit queue empty |
  | 7 | transmit queue full |
  | 8 | receive underflow |
  | 9 | receive overflow |
  | 10 | transmit underflow |
  | 11 | transmit overflow |
  | 12 | header address missing |

- R10: The level output equals the flag input sampled on the previous clock edge.
- R11: A mask write replaces the whole mask with the written data. Without a write, the mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flags_i | input | NUM_FLAGS | Level status flags from the engine |
| mask_wr_en | input | 1 | Load the mask register this cycle |
| mask_wr_data | input | NUM_FLAGS | New mask value |
| clr_wr_en | input | 1 | Apply a write-one-to-clear this cycle |
| clr_wr_data | input | NUM_FLAGS | Bits to clear (1 = clear) |
| cause_o | output | NUM_FLAGS | Latched interrupt causes |
| mask_o | output | NUM_FLAGS | Current mask |
| level_o | output | NUM_FLAGS | Flags as sampled on the previous edge |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a clear and a new rising edge landing on the same bit in the same cycle. The flag must first drop, and the clear must then be issued exactly as it rises again. Random stimulus seldom lines this up, so a directed sequence sets the cause, lowers the flag, and then raises it together with the clear. A second hard case is a flag held high across a clear, which must stay silent. The random phase toggles each flag only rarely, so long high stretches overlap many clear writes, and the bench model checks every cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  parameter int unsigned FLAG_COUNT = 13;

  typedef enum int unsigned {
    IDX_DONE       = 0,
    IDX_IDLE_RDY   = 1,
    IDX_RXQ_RDY    = 2,
    IDX_TXQ_RDY    = 3,
    IDX_RXQ_EMPTY  = 4,
    IDX_RXQ_FULL   = 5,
    IDX_TXQ_EMPTY  = 6,
    IDX_TXQ_FULL   = 7,
    IDX_RX_UNDER   = 8,
    IDX_RX_OVER    = 9,
    IDX_TX_UNDER   = 10,
    IDX_TX_OVER    = 11,
    IDX_HDR_NOADDR = 12
  } flag_idx_e;

endpackage

// File: rtl/eirq_edge_detect.sv
module eirq_edge_detect #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_in,
  output logic [WIDTH-1:0] level_prev,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] prev_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[b] <= 1'b0;
      else     prev_q[b] <= level_in[b];
    end
    assign rise[b] = level_in[b] & ~prev_q[b];
  end

  assign level_prev = prev_q;

endmodule

// File: rtl/eirq_cause_bank.sv
module eirq_cause_bank #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_vec,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] cause
);

  logic [WIDTH-1:0] cause_q;
  logic [WIDTH-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_vec : '0;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             cause_q[b] <= 1'b0;
      else if (set_vec[b]) cause_q[b] <= 1'b1;
      else if (clr_eff[b]) cause_q[b] <= 1'b0;
    end
  end

  assign cause = cause_q;

endmodule

// File: rtl/eirq_mask_reg.sv
module eirq_mask_reg #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] mask
);

  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end

  assign mask = mask_q;

endmodule

// File: rtl/eirq_combine.sv
module eirq_combine #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cause,
  input  logic [WIDTH-1:0] mask,
  output logic             irq
);

  logic [WIDTH-1:0] gated;
  logic             irq_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_gate
    assign gated[b] = cause[b] & mask[b];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |gated;
  end

  assign irq = irq_q;

endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status #(
  parameter int unsigned NUM_FLAGS = eirq_pkg::FLAG_COUNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 mask_wr_en,
  input  logic [NUM_FLAGS-1:0] mask_wr_data,
  input  logic                 clr_wr_en,
  input  logic [NUM_FLAGS-1:0] clr_wr_data,
  output logic [NUM_FLAGS-1:0] cause_o,
  output logic [NUM_FLAGS-1:0] mask_o,
  output logic [NUM_FLAGS-1:0] level_o,
  output logic                 irq_o
);

  logic [NUM_FLAGS-1:0] rise_w;
  logic [NUM_FLAGS-1:0] cause_w;
  logic [NUM_FLAGS-1:0] mask_w;

  eirq_edge_detect #(.WIDTH(NUM_FLAGS)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .level_in   (flags_i),
    .level_prev (level_o),
    .rise       (rise_w)
  );

  eirq_cause_bank #(.WIDTH(NUM_FLAGS)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .set_vec (rise_w),
    .clr_en  (clr_wr_en),
    .clr_vec (clr_wr_data),
    .cause   (cause_w)
  );

  eirq_mask_reg #(.WIDTH(NUM_FLAGS)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask    (mask_w)
  );

  eirq_combine #(.WIDTH(NUM_FLAGS)) u_comb (
    .clk   (clk),
    .rst   (rst),
    .cause (cause_w),
    .mask  (mask_w),
    .irq   (irq_o)
  );

  assign cause_o = cause_w;
  assign mask_o  = mask_w;

endmodule

// File: rtl/edge_irq_status_chk.sv
module edge_irq_status_chk #(
  parameter int unsigned NUM_FLAGS = 13
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_FLAGS-1:0] flags_i,
  input logic                 mask_wr_en,
  input logic [NUM_FLAGS-1:0] mask_wr_data,
  input logic                 clr_wr_en,
  input logic [NUM_FLAGS-1:0] clr_wr_data,
  input logic [NUM_FLAGS-1:0] cause_o,
  input logic [NUM_FLAGS-1:0] mask_o,
  input logic [NUM_FLAGS-1:0] level_o,
  input logic                 irq_o
);

  logic [NUM_FLAGS-1:0] edge_seen;
  logic [NUM_FLAGS-1:0] clr_seen;
  logic [NUM_FLAGS-1:0] wdata_seen;

  assign edge_seen  = flags_i & ~level_o;
  assign clr_seen   = clr_wr_en ? clr_wr_data : '0;
  assign wdata_seen = mask_wr_data;

  // R2
  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((cause_o & $past(edge_seen)) == $past(edge_seen)));

  // R3
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((cause_o & ~$past(cause_o) & ~$past(edge_seen)) == '0));

  // R4
  assert_clear_works_R4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((cause_o & $past(clr_seen) & ~$past(edge_seen)) == '0));

  // R6
  assert_irq_registered_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_o == (|($past(cause_o) & $past(mask_o)))));

  // R7
  assert_zero_mask_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_o == '0) |=> !irq_o);

  // R10
  assert_level_copy_R10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (level_o == $past(flags_i)));

  // R11
  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !mask_wr_en |=> $stable(mask_o));

  assert_mask_load_R11: assert property (@(posedge clk) disable iff (rst)
    mask_wr_en |=> (mask_o == $past(wdata_seen)));

endmodule

bind edge_irq_status edge_irq_status_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (.*);

// File: tb/edge_irq_status_tb.sv
module edge_irq_status_tb;

  localparam int unsigned W = eirq_pkg::FLAG_COUNT;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] flags_i = '0;
  logic         mask_wr_en = 1'b0;
  logic [W-1:0] mask_wr_data = '0;
  logic         clr_wr_en = 1'b0;
  logic [W-1:0] clr_wr_data = '0;
  logic [W-1:0] cause_o, mask_o, level_o;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_prev = '0, m_cause = '0, m_mask = '0;
  logic         m_irq = 1'b0;

  always #10 clk = ~clk;

  edge_irq_status #(.NUM_FLAGS(W)) u_dut (
    .clk(clk), .rst(rst), .flags_i(flags_i),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
    .cause_o(cause_o), .mask_o(mask_o), .level_o(level_o), .irq_o(irq_o)
  );

  function automatic logic [W-1:0] bitv(input int unsigned i);
    return W'(1) << i;
  endfunction

  function automatic logic [W-1:0] next_cause(input logic [W-1:0] c, f, p,
                                              input logic ce, input logic [W-1:0] cd);
    return (c & ~(ce ? cd : '0)) | (f & ~p);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] f, input logic mwe, input logic [W-1:0] mwd,
                      input logic cwe, input logic [W-1:0] cwd);
    flags_i = f; mask_wr_en = mwe; mask_wr_data = mwd;
    clr_wr_en = cwe; clr_wr_data = cwd;
    m_irq   = |(m_cause & m_mask);
    m_cause = next_cause(m_cause, f, m_prev, cwe, cwd);
    m_mask  = mwe ? mwd : m_mask;
    m_prev  = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic compare_all();
    chk("R2/R3/R4/R5 cause", cause_o, m_cause);
    chk("R11 mask", mask_o, m_mask);
    chk("R10 level", level_o, m_prev);
    chk("R6 irq", W'(irq_o), W'(m_irq));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 cause", cause_o, '0);
    chk("R1 mask", mask_o, '0);
    chk("R1 level", level_o, '0);
    chk("R1 irq", W'(irq_o), '0);
    rst = 1'b0;

    // R2 / R9: done flag at bit 0 rises
    step(bitv(eirq_pkg::IDX_DONE), 0, '0, 0, '0);
    chk("R2 rise", cause_o, W'(1));
    chk("R9 done at bit 0", cause_o, bitv(0));
    chk("R7 irq masked", W'(irq_o), '0);

    // R3: held flag, clear all, stays clear
    step(bitv(0), 0, '0, 1, ALL1);
    chk("R4 clear all", cause_o, '0);
    step(bitv(0), 0, '0, 0, '0);
    chk("R3 held no re-set", cause_o, '0);

    // R9 transmit-ready at bit 3; R5 edge beats clear
    step(bitv(eirq_pkg::IDX_TXQ_RDY), 0, '0, 0, '0);
    chk("R9 txq ready at bit 3", cause_o, W'(8));
    step('0, 0, '0, 0, '0);
    step(bitv(3) | bitv(7), 0, '0, 1, bitv(3));
    chk("R5 edge wins clear", cause_o, W'(8) | W'(128));
    // R4 partial clear keeps others
    step('0, 0, '0, 1, bitv(7));
    chk("R4 partial clear", cause_o, W'(8));

    // R6 latency, R8 mask toggle
    step('0, 1, bitv(3), 0, '0);
    chk("R11 mask loaded", mask_o, W'(8));
    chk("R6 irq not yet", W'(irq_o), '0);
    step('0, 0, '0, 0, '0);
    chk("R6 irq raised", W'(irq_o), W'(1));
    step('0, 1, '0, 0, '0);
    chk("R6 irq one cycle late", W'(irq_o), W'(1));
    step('0, 0, '0, 0, '0);
    chk("R7 zero mask irq low", W'(irq_o), '0);
    chk("R8 cause kept", cause_o, W'(8));
    step('0, 1, bitv(3), 0, '0);
    step('0, 0, '0, 0, '0);
    chk("R8 irq reasserted", W'(irq_o), W'(1));
    step('0, 0, '0, 1, ALL1);
    step('0, 0, '0, 0, '0);
    chk("R4 all-ones clears irq", W'(irq_o), '0);

    // R10 level copy, R11 replace
    step(W'(13'h0ABC), 1, W'(13'h000F), 0, '0);
    chk("R10 level copy", level_o, W'(13'h0ABC));
    step(W'(13'h0ABC), 1, W'(13'h00F0), 0, '0);
    chk("R11 mask replaced", mask_o, W'(13'h00F0));
    compare_all();

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] f, tog;
      logic mwe, cwe;
      tog = '0;
      for (int b = 0; b < int'(W); b++) tog[b] = ($urandom % 6) == 0;
      f   = m_prev ^ tog;
      mwe = ($urandom % 6) == 0;
      cwe = ($urandom % 3) == 0;
      step(f, mwe, W'($urandom), cwe, W'($urandom));
      compare_all();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule